// File: doc/BRIEF.md
# Debounced Input Port with Edge-Triggered Interrupt

This block watches a bank of general-purpose pins, filters each one against contact bounce over a programmable number of millisecond ticks, and presents the filtered levels as a port image. Each pin can flag a rising or a falling transition of its filtered level. Flags stay set until the port image is read. An active-low interrupt line, meant to drive an open-drain pad, is pulled low while any flagged pin is unmasked.

A surrounding register file supplies the direction word, the filter-time code, the mask word and the edge-select word. A free-running timer supplies a one-cycle millisecond tick. The read path pulses `rd_ack_i` when software reads the port image. Pins set as outputs are still filtered, so the image shows their level. Their flags are held clear. A pin that returns to input mode is blind to transitions for one full filter period, so the change of direction cannot raise a false interrupt.

Top module: `gpin_debounce_irq`

## Requirements
- R1: In the cycle after a synchronous reset, `value_o` is all ones, `pend_o` is all zeros and `irq_n_o` is 1 (released).
- R2: The filter period is 2^n ticks, where n is `dbnc_sel_i`, for n = 0 to 5. Codes 6 and 7 behave as code 5, which is 32 ticks.
- R3: A raw pin passes through a two-flop synchronizer. The filtered bit takes a new level only on the tick that completes a full period of consecutive ticks during which the synchronized level differed from the filtered bit. Any return to the filtered level restarts the count.
- R4: `edge_sel_i` bit value 0 selects the rising edge and 1 selects the falling edge. A pin's flag is set when its filtered bit changes in the selected direction while the pin is an armed input. A change in the other direction sets nothing.
- R5: After reset, and after a pin's direction bit goes from 1 to 0, that pin is blind for one full filter period counted in ticks. A filtered change on the tick that completes this period is not flagged.
- R6: While a pin's direction bit is 1 (output), its flag is cleared and no transition of it is flagged.
- R7: Flags are sticky. A one-cycle `rd_ack_i` clears all of them. A flag that is being set in the same cycle as `rd_ack_i` stays set.
- R8: `irq_n_o` is registered. It is 0 exactly when, in the previous cycle, some pin had its flag set and its mask bit at 0. Mask bits never change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Raw pin levels, asynchronous |
| dir_i | input | NPINS | Per-pin direction: 0 = input, 1 = output |
| dbnc_sel_i | input | SEL_W | Filter-time code n; period is 2^n ticks |
| mask_i | input | NPINS | Per-pin interrupt mask: 1 = masked |
| edge_sel_i | input | NPINS | Per-pin edge: 0 = rising, 1 = falling |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| rd_ack_i | input | 1 | Pulse when the port image is read; clears the flags |
| value_o | output | NPINS | Filtered port image |
| pend_o | output | NPINS | Sticky per-pin edge flags |
| irq_n_o | output | 1 | Active-low interrupt, drives an open-drain pad |

## Verification
The bound checker watches the following on every cycle:
- the reset image;
- that filtered bits move only on a tick;
- that a flag rises only with a filtered change in its selected direction;
- that flags fall only on an acknowledge or an output setting;
- that output pins hold no flag;
- that the interrupt line follows the previous cycle's unmasked flags.

The exact tick on which a level is accepted, the restart of the count on bounce, the clamping of large filter codes, the blind window after a pin returns to input mode, and a set winning over a simultaneous acknowledge show only in the bench's scenarios. There the bench compares the block against its behavioural model.

// File: rtl/gpin_dbi_pkg.sv
package gpin_dbi_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  // Filter period in ticks for a code, clamped to the largest exponent.
  function automatic int unsigned dbi_period(int unsigned code, int unsigned max_exp);
    int unsigned e;
    e = (code > max_exp) ? max_exp : code;
    return 32'd1 << e;
  endfunction

endpackage

// File: rtl/gpin_dbi_sync.sv
module gpin_dbi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gpin_dbi_filter.sv
module gpin_dbi_filter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             val_o,
  output logic             chg_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             val_q;
  logic             differ;
  logic [CNT_W-1:0] cnt_inc;

  assign differ  = smp_i ^ val_q;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign chg_o   = differ & tick_i & (cnt_inc >= period_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= 1'b1;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (chg_o) begin
      val_q <= smp_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_inc;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/gpin_dbi_arm.sv
module gpin_dbi_arm #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_out_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             armed_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || is_out_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q && tick_i) begin
      if (cnt_inc >= period_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/gpin_dbi_irq.sv
module gpin_dbi_irq #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pend_i,
  input  logic [NPINS-1:0] mask_i,
  output logic             irq_n_o
);
  logic irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|(pend_i & ~mask_i);
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/gpin_debounce_irq.sv
module gpin_debounce_irq
  import gpin_dbi_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int MAX_EXP     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(MAX_EXP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [SEL_W-1:0] dbnc_sel_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] edge_sel_i,
  input  logic             ms_tick_i,
  input  logic             rd_ack_i,
  output logic [NPINS-1:0] value_o,
  output logic [NPINS-1:0] pend_o,
  output logic             irq_n_o
);
  localparam int CNT_W = MAX_EXP + 1;

  logic [CNT_W-1:0] period;
  assign period = CNT_W'(dbi_period(32'(dbnc_sel_i), MAX_EXP));

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic smp, val, chg, armed, hit, pend_q;

      gpin_dbi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_i[i]), .q_o(smp)
      );

      gpin_dbi_filter #(.CNT_W(CNT_W)) u_filt (
        .clk(clk), .rst(rst), .smp_i(smp), .tick_i(ms_tick_i),
        .period_i(period), .val_o(val), .chg_o(chg)
      );

      gpin_dbi_arm #(.CNT_W(CNT_W)) u_arm (
        .clk(clk), .rst(rst), .is_out_i(dir_i[i]), .tick_i(ms_tick_i),
        .period_i(period), .armed_o(armed)
      );

      // smp is the level being accepted; compare with the selected edge.
      assign hit = chg & armed & ~dir_i[i] &
                   ((edge_kind_e'(edge_sel_i[i]) == EDGE_RISE) ? smp : ~smp);

      always_ff @(posedge clk) begin
        if (rst || dir_i[i]) pend_q <= 1'b0;
        else if (hit)        pend_q <= 1'b1;
        else if (rd_ack_i)   pend_q <= 1'b0;
      end

      assign value_o[i] = val;
      assign pend_o[i]  = pend_q;
    end
  endgenerate

  gpin_dbi_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst(rst), .pend_i(pend_o), .mask_i(mask_i), .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/gpin_debounce_irq_chk.sv
module gpin_debounce_irq_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] dir_i,
  input logic [NPINS-1:0] mask_i,
  input logic [NPINS-1:0] edge_sel_i,
  input logic             ms_tick_i,
  input logic             rd_ack_i,
  input logic [NPINS-1:0] value_o,
  input logic [NPINS-1:0] pend_o,
  input logic             irq_n_o
);
  assert_reset_image_R1: assert property (@(posedge clk)
    $past(rst) |-> (value_o == '1 && pend_o == '0 && irq_n_o));

  assert_value_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (value_o != $past(value_o)) |-> $past(ms_tick_i));

  assert_flag_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
    ((pend_o & ~$past(pend_o)) &
     ~((value_o ^ $past(value_o)) & (value_o ^ $past(edge_sel_i)))) == '0);

  assert_output_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_o & $past(dir_i)) == '0);

  assert_flag_clear_cause_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_ack_i) == 1'b0) |->
      (($past(pend_o) & ~pend_o & ~$past(dir_i)) == '0));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == ~|($past(pend_o) & ~$past(mask_i)));
endmodule

bind gpin_debounce_irq gpin_debounce_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .dir_i(dir_i), .mask_i(mask_i), .edge_sel_i(edge_sel_i),
  .ms_tick_i(ms_tick_i), .rd_ack_i(rd_ack_i), .value_o(value_o),
  .pend_o(pend_o), .irq_n_o(irq_n_o)
);

// File: tb/gpin_debounce_irq_test.sv
`timescale 1ns/1ps
module gpin_debounce_irq_test;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_i = '1;
  logic [N-1:0] dir_i = '0;
  logic [2:0]   dbnc_sel_i = 3'd2;
  logic [N-1:0] mask_i = '1;
  logic [N-1:0] edge_sel_i = '0;
  logic         ms_tick_i = 1'b0;
  logic         rd_ack_i = 1'b0;
  logic [N-1:0] value_o, pend_o;
  logic         irq_n_o;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpin_debounce_irq uut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .dir_i(dir_i), .dbnc_sel_i(dbnc_sel_i),
    .mask_i(mask_i), .edge_sel_i(edge_sel_i), .ms_tick_i(ms_tick_i),
    .rd_ack_i(rd_ack_i), .value_o(value_o), .pend_o(pend_o), .irq_n_o(irq_n_o)
  );

  // Behavioural reference model
  logic [N-1:0] m_s1, m_s2, m_val, m_armed, m_pend;
  logic         m_irq_n;
  int           m_cnt [N];
  int           m_bcnt[N];

  always @(posedge clk) begin
    int per;
    logic chg, nv, set;
    per = 1 << ((dbnc_sel_i > 3'd5) ? 5 : int'(dbnc_sel_i));
    if (rst) begin
      m_s1 = '1; m_s2 = '1; m_val = '1; m_armed = '0; m_pend = '0; m_irq_n = 1'b1;
      for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_bcnt[i] = 0; end
    end else begin
      m_irq_n = ~|(m_pend & ~mask_i);
      for (int i = 0; i < N; i++) begin
        chg = 1'b0; nv = m_val[i];
        if (m_s2[i] == m_val[i]) m_cnt[i] = 0;
        else if (ms_tick_i) begin
          if (m_cnt[i] + 1 >= per) begin chg = 1'b1; nv = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end
        set = chg && m_armed[i] && !dir_i[i] && (nv == !edge_sel_i[i]);
        if (dir_i[i]) begin m_armed[i] = 1'b0; m_bcnt[i] = 0; end
        else if (!m_armed[i] && ms_tick_i) begin
          if (m_bcnt[i] + 1 >= per) begin m_armed[i] = 1'b1; m_bcnt[i] = 0; end
          else m_bcnt[i]++;
        end
        if (dir_i[i]) m_pend[i] = 1'b0;
        else if (set) m_pend[i] = 1'b1;
        else if (rd_ack_i) m_pend[i] = 1'b0;
        m_val[i] = nv;
      end
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
  end

  // Compare with the model on every cycle, away from the clock edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 3;
      if (value_o !== m_val) begin
        bad++; $display("FAIL R3 model value: actual=%h expected=%h", value_o, m_val);
      end
      if (pend_o !== m_pend) begin
        bad++; $display("FAIL R4 model flags: actual=%h expected=%h", pend_o, m_pend);
      end
      if (irq_n_o !== m_irq_n) begin
        bad++; $display("FAIL R8 model irq_n: actual=%0b expected=%0b", irq_n_o, m_irq_n);
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ms_tick_i = 1'b1;
      @(negedge clk) ms_tick_i = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk) rd_ack_i = 1'b1;
    @(negedge clk) rd_ack_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset image
    chk(value_o == '1, "R1 value", value_o, 16'hFFFF);
    chk(pend_o == '0, "R1 flags", pend_o, 0);
    chk(irq_n_o == 1'b1, "R1 irq_n", irq_n_o, 1);

    ticks(4);              // R5 blind window after reset (period 4)
    mask_i = 16'hFFFE;

    // R4: falling edge on a rising-select pin sets nothing; R3 timing
    pin_i[0] = 1'b0; settle(); ticks(3);
    chk(value_o[0] == 1'b1, "R3 not yet accepted", value_o[0], 1);
    ticks(1);
    chk(value_o[0] == 1'b0, "R3 accepted after period", value_o[0], 0);
    chk(pend_o[0] == 1'b0, "R4 wrong edge ignored", pend_o[0], 0);
    pin_i[0] = 1'b1; settle(); ticks(4);
    chk(pend_o[0] == 1'b1, "R4 rising flagged", pend_o[0], 1);
    @(negedge clk);
    chk(irq_n_o == 1'b0, "R8 irq asserted", irq_n_o, 0);

    // R3 bounce restarts the count
    pin_i[1] = 1'b0; settle(); ticks(2);
    pin_i[1] = 1'b1; settle(); ticks(2);
    pin_i[1] = 1'b0; settle(); ticks(3);
    chk(value_o[1] == 1'b1, "R3 bounce restarts", value_o[1], 1);
    ticks(1);
    chk(value_o[1] == 1'b0, "R3 stable accepted", value_o[1], 0);

    // R7 acknowledge clears
    ack();
    chk(pend_o == '0, "R7 ack clears", pend_o, 0);
    @(negedge clk);
    chk(irq_n_o == 1'b1, "R8 irq released", irq_n_o, 1);

    // R4 falling select, R8 mask
    edge_sel_i[2] = 1'b1;
    pin_i[2] = 1'b0; settle(); ticks(4);
    chk(pend_o[2] == 1'b1, "R4 falling flagged", pend_o[2], 1);
    repeat (2) @(negedge clk);
    chk(irq_n_o == 1'b1, "R8 masked flag silent", irq_n_o, 1);
    mask_i[2] = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq_n_o == 1'b0, "R8 unmasked flag drives", irq_n_o, 0);
    ack(); @(negedge clk);

    // R6 output pins; R5 blind window after re-arm
    dir_i[3] = 1'b1; mask_i[3] = 1'b0;
    pin_i[3] = 1'b0; settle(); ticks(4);
    edge_sel_i[3] = 1'b1;
    pin_i[3] = 1'b1; settle(); ticks(4);
    pin_i[3] = 1'b0; settle(); ticks(4);
    chk(value_o[3] == 1'b0, "R6 output still filtered", value_o[3], 0);
    chk(pend_o[3] == 1'b0, "R6 output no flag", pend_o[3], 0);
    edge_sel_i[3] = 1'b0;
    @(negedge clk) dir_i[3] = 1'b0;
    pin_i[3] = 1'b1; settle(); ticks(4);
    chk(value_o[3] == 1'b1, "R5 level accepted while blind", value_o[3], 1);
    chk(pend_o[3] == 1'b0, "R5 blind window", pend_o[3], 0);
    pin_i[3] = 1'b0; settle(); ticks(4);
    pin_i[3] = 1'b1; settle(); ticks(4);
    chk(pend_o[3] == 1'b1, "R5 armed after window", pend_o[3], 1);
    @(negedge clk) dir_i[3] = 1'b1;
    @(negedge clk);
    chk(pend_o[3] == 1'b0, "R6 output clears flag", pend_o[3], 0);
    dir_i[3] = 1'b0;
    ticks(4); ack();

    // R2 clamp of large codes, and code 0
    dbnc_sel_i = 3'd7;
    pin_i[4] = 1'b0; settle(); ticks(31);
    chk(value_o[4] == 1'b1, "R2 code 7 not before 32", value_o[4], 1);
    ticks(1);
    chk(value_o[4] == 1'b0, "R2 code 7 acts as 32", value_o[4], 0);
    dbnc_sel_i = 3'd0;
    pin_i[4] = 1'b1; settle(); ticks(1);
    chk(value_o[4] == 1'b1, "R2 code 0 one tick", value_o[4], 1);
    chk(pend_o[4] == 1'b1, "R4 rising at code 0", pend_o[4], 1);

    // R7 set wins over a simultaneous acknowledge
    pin_i[5] = 1'b0; settle(); ticks(1);
    pin_i[5] = 1'b1; settle();
    @(negedge clk) begin ms_tick_i = 1'b1; rd_ack_i = 1'b1; end
    @(negedge clk) begin ms_tick_i = 1'b0; rd_ack_i = 1'b0; end
    chk(pend_o[5] == 1'b1, "R7 set beats ack", pend_o[5], 1);
    chk(pend_o[4] == 1'b0, "R7 ack clears other", pend_o[4], 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule